// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the byte address of a memory access or branch target from a base register and either a signed 16-bit displacement or a second (index) register. A base register number of zero selects the constant zero as the base, not the contents of register zero. All arithmetic is unsigned and modulo 2^32. The block also reports two properties of the access: the operand runs past the top of the address space and continues at address 0, or the access is misaligned in a way that must raise an alignment exception.

Requests enter through a valid/ready port and results leave through a second valid/ready port, with one register stage between them. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result appears on the outputs in the following cycle with `rsp_valid` high. The result stays unchanged until a rising edge where `rsp_ready` is high. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a consumer that holds `rsp_ready` high allows one request per cycle. When `rsp_ready` is low, `req_ready` drops and back-pressure reaches the producer. Operand size is coded on `req_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.

Top module: `lsu_ea_unit`

## Requirements
- R1: With `req_use_index`=0, `rsp_ea` = base + the displacement sign-extended to 32 bits. A zero displacement gives the base itself.
- R2: With `req_use_index`=1, `rsp_ea` = base + `req_rb_val`, and `req_disp` has no effect.
- R3: The base is `req_ra_val` when `req_ra_idx` is non-zero, and 0 when `req_ra_idx` = 0, whatever value `req_ra_val` holds.
- R4: The sum is taken modulo 2^32: the carry out of bit 31 is discarded.
- R5: `rsp_wrap` is 1 exactly when `rsp_ea` + (operand length − 1) exceeds 0xFFFFFFFF, with length = 1 << `req_size`.
- R6: An access whose address is a multiple of its length never sets `rsp_align_exc`. Byte accesses are therefore never flagged.
- R7: A misaligned halfword or word access sets `rsp_align_exc` only when its bytes cross an 8-byte boundary, that is when `rsp_ea[2:0]` + length > 8.
- R8: A misaligned doubleword access (`req_size`=3, `rsp_ea[2:0]` ≠ 0) always sets `rsp_align_exc`.
- R9: `req_little_endian` does not change `rsp_align_exc`, `rsp_ea` or `rsp_wrap`. Little-endian accesses follow the same rules as big-endian ones.
- R10: With `req_string_multi`=1, `rsp_align_exc` is 0 for any address and size.
- R11: An accepted request produces `rsp_valid`=1 in the next cycle. While `rsp_valid`=1 and `rsp_ready`=0, the outputs are held stable and `req_ready` is 0.
- R12: During reset and after it, `rsp_valid` is 0 and `req_ready` is 1 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ra_idx | input | 5 | Base register number (0 selects constant zero) |
| req_ra_val | input | 32 | Base register contents |
| req_rb_val | input | 32 | Index register contents |
| req_disp | input | 16 | Signed displacement |
| req_use_index | input | 1 | 0: base + displacement, 1: base + index |
| req_size | input | 2 | Operand length code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_little_endian | input | 1 | Byte order of the access (1 = little-endian) |
| req_string_multi | input | 1 | Access belongs to a string or multiple-register transfer |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_ea | output | 32 | Effective address |
| rsp_wrap | output | 1 | Operand continues past the top address at 0 |
| rsp_align_exc | output | 1 | Alignment exception required |

## Verification
The address path is tried with positive, negative and zero displacements, with index mode fed a conflicting displacement, and with base register number zero paired with a non-zero base value. These cases separate correct sign extension, correct operand selection and the zero-base rule. Sums that overflow bit 31 and addresses just below 0xFFFFFFFF show the difference between discarding the carry and flagging operand wrap. Halfword, word and doubleword accesses are placed at offsets inside and across an 8-byte boundary, and each is repeated in both byte orders and with the string/multiple flag. These cases separate the crossing rule, the doubleword rule, the byte-order independence and the exemption. A phase with an irregular `rsp_ready` pattern and back-to-back requests shows that results are held under back-pressure and that none are lost or duplicated.

// File: rtl/lsu_ea_pkg.sv
package lsu_ea_pkg;

  // Operand length code carried on req_size.
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // Width of the naturally aligned block that halfword/word may not cross.
  localparam int unsigned BLOCK_BYTES = 8;
  localparam int unsigned BLOCK_LSB_W = $clog2(BLOCK_BYTES);

  typedef struct packed {
    logic [31:0] ea;
    logic        wrap;
    logic        align_exc;
  } ea_result_t;

endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder #(
  parameter int unsigned AW     = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [AW-1:0]     ra_val,
  input  logic [AW-1:0]     rb_val,
  input  logic [DISP_W-1:0] disp,
  input  logic              use_index,
  output logic [AW-1:0]     ea
);

  logic [AW-1:0] base_term;
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] offset_term;

  // Register number zero stands for the literal value zero.
  assign base_term = (ra_idx == '0) ? '0 : ra_val;

  generate
    if (DISP_W < AW) begin : g_sext
      assign disp_ext = {{(AW-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[AW-1:0];
    end
  endgenerate

  assign offset_term = use_index ? rb_val : disp_ext;

  // Modulo 2^AW: the carry out is simply not kept.
  assign ea = base_term + offset_term;

endmodule

// File: rtl/lsu_ea_align.sv
module lsu_ea_align
  import lsu_ea_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] ea,
  input  acc_size_e     size,
  input  logic          string_multi,
  output logic          wrap,
  output logic          align_exc
);

  localparam int unsigned LEN_W = BLOCK_LSB_W + 2;

  logic [LEN_W-1:0] len;
  logic [AW-1:0]    len_m1;
  logic [AW:0]      last_byte;
  logic [LEN_W-1:0] end_in_block;
  logic             misaligned;
  logic             crosses_block;

  assign len    = LEN_W'(1) << size;
  assign len_m1 = AW'(len) - AW'(1);

  // Address of the last operand byte; a carry means the operand wrapped.
  assign last_byte = {1'b0, ea} + {1'b0, len_m1};
  assign wrap      = last_byte[AW];

  assign misaligned    = (ea[BLOCK_LSB_W-1:0] & len_m1[BLOCK_LSB_W-1:0]) != '0;
  assign end_in_block  = LEN_W'(ea[BLOCK_LSB_W-1:0]) + len;
  assign crosses_block = end_in_block > LEN_W'(BLOCK_BYTES);

  always_comb begin
    align_exc = 1'b0;
    if (!string_multi && misaligned) begin
      unique case (size)
        SZ_DWORD:        align_exc = 1'b1;
        SZ_HALF, SZ_WORD: align_exc = crosses_block;
        default:         align_exc = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lsu_ea_unit.sv
module lsu_ea_unit
  import lsu_ea_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RIDX_W-1:0] req_ra_idx,
  input  logic [AW-1:0]     req_ra_val,
  input  logic [AW-1:0]     req_rb_val,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              req_use_index,
  input  logic [1:0]        req_size,
  input  logic              req_little_endian,
  input  logic              req_string_multi,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [AW-1:0]     rsp_ea,
  output logic              rsp_wrap,
  output logic              rsp_align_exc
);

  logic [AW-1:0] ea_next;
  logic          wrap_next;
  logic          exc_next;
  logic          accept;
  logic          unused_le;

  // Byte order does not enter any rule of this stage.
  assign unused_le = req_little_endian;

  lsu_ea_adder #(
    .AW     (AW),
    .DISP_W (DISP_W),
    .RIDX_W (RIDX_W)
  ) u_adder (
    .ra_idx    (req_ra_idx),
    .ra_val    (req_ra_val),
    .rb_val    (req_rb_val),
    .disp      (req_disp),
    .use_index (req_use_index),
    .ea        (ea_next)
  );

  lsu_ea_align #(
    .AW (AW)
  ) u_align (
    .ea           (ea_next),
    .size         (acc_size_e'(req_size)),
    .string_multi (req_string_multi),
    .wrap         (wrap_next),
    .align_exc    (exc_next)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_ea        <= '0;
      rsp_wrap      <= 1'b0;
      rsp_align_exc <= 1'b0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_ea        <= ea_next;
      rsp_wrap      <= wrap_next;
      rsp_align_exc <= exc_next;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

endmodule

// File: rtl/lsu_ea_unit_chk.sv
module lsu_ea_unit_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [RIDX_W-1:0] req_ra_idx,
  input logic [DISP_W-1:0] req_disp,
  input logic              req_use_index,
  input logic [1:0]        req_size,
  input logic              req_string_multi,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [AW-1:0]     rsp_ea,
  input logic              rsp_wrap,
  input logic              rsp_align_exc
);

  logic acc;
  assign acc = req_valid && req_ready;

  // R11: accepted request yields a result next cycle
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R11: stalled result held stable
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_ea) && $stable(rsp_wrap) && $stable(rsp_align_exc)));

  // R11: no new request while a stalled result is held
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R12: output stage is empty while in reset
  p_reset_r12: assert property (@(posedge clk)
    !rst_n |-> !rsp_valid);

  // R10: string/multiple transfers never raise the exception
  p_string_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_string_multi) |=> !rsp_align_exc);

  // R8: doubleword exception tracks the low address bits
  p_dword_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_size == 2'd3 && !req_string_multi) |=>
      (rsp_align_exc == (rsp_ea[2:0] != 3'd0)));

  // R6: byte accesses never wrap or fault
  p_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_size == 2'd0) |=> (!rsp_align_exc && !rsp_wrap));

  // R3: register number zero with displacement gives the displacement alone
  p_base0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_ra_idx == '0 && !req_use_index) |=>
      (rsp_ea == {{(AW-DISP_W){$past(req_disp[DISP_W-1])}}, $past(req_disp)}));

endmodule

bind lsu_ea_unit lsu_ea_unit_chk #(
  .AW     (AW),
  .DISP_W (DISP_W),
  .RIDX_W (RIDX_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_ra_idx       (req_ra_idx),
  .req_disp         (req_disp),
  .req_use_index    (req_use_index),
  .req_size         (req_size),
  .req_string_multi (req_string_multi),
  .rsp_valid        (rsp_valid),
  .rsp_ready        (rsp_ready),
  .rsp_ea           (rsp_ea),
  .rsp_wrap         (rsp_wrap),
  .rsp_align_exc    (rsp_align_exc)
);

// File: tb/test_lsu_ea_unit.sv
`timescale 1ns/1ps
module test_lsu_ea_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_ra_idx = '0;
  logic [31:0] req_ra_val = '0;
  logic [31:0] req_rb_val = '0;
  logic [15:0] req_disp = '0;
  logic        req_use_index = 1'b0;
  logic [1:0]  req_size = '0;
  logic        req_little_endian = 1'b0;
  logic        req_string_multi = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_ea;
  logic        rsp_wrap;
  logic        rsp_align_exc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit backpressure = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] ea;
    logic        wrap;
    logic        exc;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  lsu_ea_unit i_lsu_ea_unit (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .req_ra_idx        (req_ra_idx),
    .req_ra_val        (req_ra_val),
    .req_rb_val        (req_rb_val),
    .req_disp          (req_disp),
    .req_use_index     (req_use_index),
    .req_size          (req_size),
    .req_little_endian (req_little_endian),
    .req_string_multi  (req_string_multi),
    .rsp_valid         (rsp_valid),
    .rsp_ready         (rsp_ready),
    .rsp_ea            (rsp_ea),
    .rsp_wrap          (rsp_wrap),
    .rsp_align_exc     (rsp_align_exc)
  );

  // Reference model written from the requirements.
  function automatic exp_t model(input logic [4:0] ra_idx, input logic [31:0] ra,
                                 input logic [31:0] rb, input logic [15:0] disp,
                                 input logic idx, input logic [1:0] sz,
                                 input logic str, input string tag);
    exp_t e;
    logic [31:0] base, off;
    logic [32:0] last;
    int unsigned len;
    bit mis;
    base = (ra_idx == 5'd0) ? 32'd0 : ra;
    off  = idx ? rb : {{16{disp[15]}}, disp};
    e.ea = base + off;
    len  = 1 << sz;
    last = {1'b0, e.ea} + 33'(len - 1);
    e.wrap = last[32];
    mis = (e.ea[2:0] & 3'(len - 1)) != 3'd0;
    e.exc = !str && mis && (sz == 2'd3 || (int'(e.ea[2:0]) + len > 8));
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [4:0] ra_idx, input logic [31:0] ra,
                      input logic [31:0] rb, input logic [15:0] disp,
                      input logic idx, input logic [1:0] sz,
                      input logic le, input logic str, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_ra_idx = ra_idx; req_ra_val = ra; req_rb_val = rb; req_disp = disp;
    req_use_index = idx; req_size = sz; req_little_endian = le; req_string_multi = str;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(model(ra_idx, ra, rb, disp, idx, sz, str, tag));
    @(posedge clk);
    #0.5;
    req_valid = 1'b0;
  endtask

  // Irregular consumer during the back-pressure phase.
  int rcnt = 0;
  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    if (backpressure) rsp_ready <= (rcnt % 5 == 1) || (rcnt % 3 == 0);
    else rsp_ready <= 1'b1;
  end

  // Monitor: compare results as they are consumed; check holding under stall.
  bit held = 1'b0;
  logic [31:0] h_ea;
  logic h_wrap, h_exc;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (held) begin
          checks++;
          if (!(rsp_valid && rsp_ea == h_ea && rsp_wrap == h_wrap && rsp_align_exc == h_exc)) begin
            errors++;
            $display("FAIL R11 hold: got v=%0b ea=%h w=%0b x=%0b exp v=1 ea=%h w=%0b x=%0b",
                     rsp_valid, rsp_ea, rsp_wrap, rsp_align_exc, h_ea, h_wrap, h_exc);
          end
          checks++;
          if (req_ready !== (rsp_ready ? 1'b1 : 1'b0)) begin
            errors++;
            $display("FAIL R11 ready under stall: got %0b exp %0b", req_ready, rsp_ready);
          end
        end
        if (rsp_valid && rsp_ready) begin
          checks++;
          if (sb.size() == 0) begin
            errors++;
            $display("FAIL R11 unexpected result: got ea=%h exp none", rsp_ea);
          end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_ea !== e.ea || rsp_wrap !== e.wrap || rsp_align_exc !== e.exc) begin
              errors++;
              $display("FAIL %s: got ea=%h w=%0b x=%0b exp ea=%h w=%0b x=%0b",
                       e.tag, rsp_ea, rsp_wrap, rsp_align_exc, e.ea, e.wrap, e.exc);
            end
          end
        end
        held = rsp_valid && !rsp_ready;
        h_ea = rsp_ea; h_wrap = rsp_wrap; h_exc = rsp_align_exc;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      summary();
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 in reset: got v=%0b rdy=%0b exp v=0 rdy=1", rsp_valid, req_ready);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 after reset: got v=%0b rdy=%0b exp v=0 rdy=1", rsp_valid, req_ready);
    end

    // R11 latency: result present one cycle after acceptance
    send(5'd3, 32'h0000_1000, 32'h0, 16'h0010, 1'b0, 2'd2, 1'b0, 1'b0, "R1 positive disp");
    checks++;
    #1;
    if (rsp_valid !== 1'b1) begin
      errors++;
      $display("FAIL R11 latency: got v=%0b exp 1", rsp_valid);
    end

    send(5'd3, 32'h0000_1000, 32'h0, 16'hFFF0, 1'b0, 2'd2, 1'b0, 1'b0, "R1 negative disp");
    send(5'd7, 32'h1234_5678, 32'h0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, "R1 zero disp");
    send(5'd4, 32'h0000_2000, 32'h0000_0340, 16'h7FFF, 1'b1, 2'd2, 1'b0, 1'b0, "R2 index ignores disp");
    send(5'd0, 32'hDEAD_BEEF, 32'h0, 16'h0100, 1'b0, 2'd2, 1'b0, 1'b0, "R3 base zero disp");
    send(5'd0, 32'hDEAD_BEEF, 32'h0000_0800, 16'h0, 1'b1, 2'd3, 1'b0, 1'b0, "R3 base zero index");
    send(5'd1, 32'hFFFF_FF00, 32'h0000_0200, 16'h0, 1'b1, 2'd2, 1'b0, 1'b0, "R4 carry discarded");
    send(5'd1, 32'h0000_0010, 32'h0, 16'h8000, 1'b0, 2'd2, 1'b0, 1'b0, "R4 negative wrap below 0");
    send(5'd2, 32'hFFFF_FFFC, 32'h0, 16'h0, 1'b0, 2'd2, 1'b0, 1'b0, "R5 word at top no wrap");
    send(5'd2, 32'hFFFF_FFFE, 32'h0, 16'h0, 1'b0, 2'd2, 1'b0, 1'b1, "R5 word wraps");
    send(5'd2, 32'hFFFF_FFF9, 32'h0, 16'h0, 1'b0, 2'd3, 1'b0, 1'b0, "R5 dword wraps");
    send(5'd2, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b0, 2'd0, 1'b0, 1'b0, "R5 byte at top no wrap");
    send(5'd5, 32'h0000_4000, 32'h0, 16'h0, 1'b0, 2'd3, 1'b0, 1'b0, "R6 aligned dword");
    send(5'd5, 32'h0000_4003, 32'h0, 16'h0, 1'b0, 2'd0, 1'b0, 1'b0, "R6 odd byte");
    send(5'd5, 32'h0000_4002, 32'h0, 16'h0, 1'b0, 2'd2, 1'b0, 1'b0, "R7 word inside block");
    send(5'd5, 32'h0000_4006, 32'h0, 16'h0, 1'b0, 2'd2, 1'b0, 1'b0, "R7 word crosses block");
    send(5'd5, 32'h0000_4005, 32'h0, 16'h0, 1'b0, 2'd1, 1'b0, 1'b0, "R7 half inside block");
    send(5'd5, 32'h0000_4007, 32'h0, 16'h0, 1'b0, 2'd1, 1'b0, 1'b0, "R7 half crosses block");
    send(5'd5, 32'h0000_4004, 32'h0, 16'h0, 1'b0, 2'd3, 1'b0, 1'b0, "R8 dword misaligned 4");
    send(5'd5, 32'h0000_4001, 32'h0, 16'h0, 1'b0, 2'd3, 1'b0, 1'b0, "R8 dword misaligned 1");
    send(5'd5, 32'h0000_4006, 32'h0, 16'h0, 1'b0, 2'd2, 1'b1, 1'b0, "R9 LE word crosses");
    send(5'd5, 32'h0000_4002, 32'h0, 16'h0, 1'b0, 2'd2, 1'b1, 1'b0, "R9 LE word inside");
    send(5'd5, 32'h0000_4004, 32'h0, 16'h0, 1'b0, 2'd3, 1'b1, 1'b0, "R9 LE dword misaligned");
    send(5'd5, 32'h0000_4006, 32'h0, 16'h0, 1'b0, 2'd2, 1'b1, 1'b1, "R10 LE string word");
    send(5'd5, 32'h0000_4004, 32'h0, 16'h0, 1'b0, 2'd3, 1'b0, 1'b1, "R10 multi dword");
    send(5'd5, 32'h0000_4007, 32'h0, 16'h0, 1'b0, 2'd1, 1'b0, 1'b1, "R10 string half");

    // R11: back-pressure with back-to-back requests
    backpressure = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send(5'(i % 4), 32'h0001_0000 + 32'(i * 3), 32'(i * 5), 16'(i * 7 - 100),
           1'(i % 3 == 0), 2'(i % 4), 1'(i % 2), 1'(i % 7 == 0), "R11 stream under back-pressure");
    end
    backpressure = 1'b0;
    repeat (20) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 results lost: got %0d pending exp 0", sb.size());
    end
    finished = 1'b1;
    summary();
  end

endmodule